// File: doc/BRIEF.md
# Seven-to-one four-lane pixel serializer

The block turns a 28-bit pixel word into four serial data lanes and one forwarded clock lane. Everything runs on a bit clock at seven times the pixel rate. The pixel clock arrives as an ordinary input and is sampled on the bit clock. A select input decides whether a word is captured on the pixel clock's rising edge or on its falling edge. Each serial frame lasts seven bit-clock cycles. In every frame each data lane sends seven bits of one captured word, in a fixed, non-sequential order. The clock lane sends a pattern that is high for four slots and low for three, and it rises at slot 0.

A captured word enters the serial stage only at the boundary where slot 6 ends and slot 0 begins, so no frame ever mixes two words. A run input acts as the shutdown control. When run is low, the driver enable drops and every lane is held low; the external differential drivers are then in high impedance. When run rises, the enable returns at once, but the lanes stay low until a parameterised lock delay has passed. That delay stands in for the settling time of the clock multiplier. The first valid frame then starts at slot 0.

Top module: `pix_serializer_7to1`

## Requirements
- R1: A word is captured from `pix_word` at a bit-clock edge where the sampled `pix_clk` shows the selected transition. With `edge_rise`=1 that is a rising transition (previous sample 0, current sample 1); with `edge_rise`=0 it is a falling one. The capture register resets to zero.
- R2: The serial stage loads only at the slot-6 to slot-0 boundary. It takes the captured word as it stood before that edge, and all 28 bits of one frame come from that single word.
- R3: Lane 0 (`lane_dat[0]`) carries bits 1, 0, 7, 6, 4, 3, 2 of the word in slots 0 to 6.
- R4: Lane 1 (`lane_dat[1]`) carries bits 9, 8, 18, 15, 14, 13, 12 in slots 0 to 6.
- R5: Lane 2 (`lane_dat[2]`) carries bits 20, 19, 26, 25, 24, 22, 21 in slots 0 to 6.
- R6: Lane 3 (`lane_dat[3]`) carries bits 5, 27, 23, 17, 16, 11, 10 in slots 0 to 6.
- R7: While valid, `lane_clk` is 1 in slots 0 to 3 and 0 in slots 4 to 6.
- R8: The cycle after `run` is sampled low, `lane_oe` is 0 and all lanes are 0.
- R9: `lane_oe` is 1 in the cycle after `run` is sampled high. All lanes stay 0 until the LOCK_CYCLES-th consecutive edge at which `run` is high. Slot 0 of the first valid frame appears right after that edge. A drop of `run` during the wait restarts the count.
- R10: While `rst` is high, `lane_oe` and all lanes read 0 from the next edge on.
- R11: Slots advance by one per bit-clock cycle, so while valid `lane_clk` rises exactly every 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Pixel clock, sampled on clk |
| edge_rise | input | 1 | 1: capture on the rising pixel edge, 0: on the falling edge |
| pix_word | input | 28 | Parallel pixel word |
| run | input | 1 | 1: operate, 0: shut down |
| lane_dat | output | 4 | Serial data lanes 0 to 3 |
| lane_clk | output | 1 | Forwarded clock lane |
| lane_oe | output | 1 | Driver enable; 0 means the lanes are in high impedance |

## Verification
The hardest case to reach is a pixel edge that falls on the same bit-clock edge as a frame load. In that case the load must take the older word, and the new word must wait for the next frame. The bench moves the phase of its pixel clock relative to the frame several times, and it re-locks with both capture polarities, so that capture edges land on every slot, including the boundary. It also drops `run` partway through a lock wait, to show that the count restarts rather than resumes.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;
  localparam int LANES = 4;
  localparam int SLOTS = 7;
  localparam int WORD  = LANES * SLOTS;

  // Source bit of the word for a given lane and serial slot
  function automatic int src_bit(input int lane, input int slot);
    int idx;
    idx = lane * SLOTS + slot;
    case (idx)
      0:  return 1;   1:  return 0;   2:  return 7;   3:  return 6;
      4:  return 4;   5:  return 3;   6:  return 2;
      7:  return 9;   8:  return 8;   9:  return 18;  10: return 15;
      11: return 14;  12: return 13;  13: return 12;
      14: return 20;  15: return 19;  16: return 26;  17: return 25;
      18: return 24;  19: return 22;  20: return 21;
      21: return 5;   22: return 27;  23: return 23;  24: return 17;
      25: return 16;  26: return 11;  27: return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/pix_capture.sv
module pix_capture #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pix_clk,
  input  logic         edge_rise,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_q
);
  logic pclk_q;
  logic hit;

  always_comb begin
    if (edge_rise) hit = pix_clk & ~pclk_q;
    else           hit = ~pix_clk & pclk_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_q <= 1'b0;
      word_q <= '0;
    end else begin
      pclk_q <= pix_clk;
      if (hit) word_q <= word_in;
    end
  end

  // R1
  cap_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (word_q != $past(word_q)) |-> $past(hit));
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer #(
  parameter int SLOTS       = 7,
  parameter int LOCK_CYCLES = 5670,
  localparam int PW   = $clog2(SLOTS),
  localparam int CW   = $clog2(LOCK_CYCLES + 1),
  localparam int LAST = SLOTS - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [PW-1:0] phase_q,
  output logic          valid_q,
  output logic          oe_q,
  output logic          load
);
  logic [CW-1:0] cnt_q;
  logic          lock_done;

  assign lock_done = run && !valid_q && (cnt_q == CW'(LOCK_CYCLES - 1));
  assign load      = (phase_q == PW'(LAST));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
      phase_q <= PW'(LAST);
    end else begin
      if (!valid_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (lock_done) valid_q <= 1'b1;
      end
      if (phase_q == PW'(LAST))
        phase_q <= (valid_q || lock_done) ? '0 : PW'(LAST);
      else
        phase_q <= phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= run;
  end

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> $past(run));
  // R11
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase_q <= PW'(LAST));
  // R2
  slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && $past(valid_q) && phase_q == '0) |-> $past(phase_q) == PW'(LAST));
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] par,
  output logic         ser
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)       sh_q <= '0;
    else if (load) sh_q <= par;
    else           sh_q <= {1'b0, sh_q[W-1:1]};
  end

  assign ser = sh_q[0];
endmodule

// File: rtl/pix_serializer_7to1.sv
module pix_serializer_7to1
  import pix_ser_pkg::*;
#(
  parameter int LOCK_CYCLES = 5670,
  parameter logic [SLOTS-1:0] CLK_PATTERN = 7'b0001111,
  localparam int PW = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pix_clk,
  input  logic            edge_rise,
  input  logic [WORD-1:0] pix_word,
  input  logic            run,
  output logic [LANES-1:0] lane_dat,
  output logic            lane_clk,
  output logic            lane_oe
);
  logic [WORD-1:0]  cap_word;
  logic [PW-1:0]    phase;
  logic             valid;
  logic             oe;
  logic             load;
  logic [LANES-1:0] ser;
  logic             clk_ser;

  pix_capture #(.W(WORD)) u_cap (
    .clk(clk), .rst(rst), .pix_clk(pix_clk), .edge_rise(edge_rise),
    .word_in(pix_word), .word_q(cap_word)
  );

  frame_sequencer #(.SLOTS(SLOTS), .LOCK_CYCLES(LOCK_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .run(run), .phase_q(phase),
    .valid_q(valid), .oe_q(oe), .load(load)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] par;
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign par[s] = cap_word[src_bit(l, s)];
    end
    lane_shifter #(.W(SLOTS)) u_sh (
      .clk(clk), .rst(rst), .load(load), .par(par), .ser(ser[l])
    );
  end

  lane_shifter #(.W(SLOTS)) u_clk_sh (
    .clk(clk), .rst(rst), .load(load), .par(CLK_PATTERN), .ser(clk_ser)
  );

  assign lane_dat = valid ? ser : '0;
  assign lane_clk = valid & clk_ser;
  assign lane_oe  = oe;

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lane_oe |-> (lane_dat == '0 && !lane_clk));
  // R7
  clk_high_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && phase < PW'(4)) |-> lane_clk);
  // R7
  clk_low_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && phase >= PW'(4)) |-> !lane_clk);
endmodule

// File: tb/pix_serializer_7to1_test.sv
module pix_serializer_7to1_test;
  localparam int LOCK = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_clk = 1'b0;
  logic       edge_rise = 1'b1;
  logic [27:0] pix_word = '0;
  logic       run = 1'b0;
  logic [3:0] lane_dat;
  logic       lane_clk;
  logic       lane_oe;

  pix_serializer_7to1 #(.LOCK_CYCLES(LOCK)) uut (
    .clk(clk), .rst(rst), .pix_clk(pix_clk), .edge_rise(edge_rise),
    .pix_word(pix_word), .run(run), .lane_dat(lane_dat),
    .lane_clk(lane_clk), .lane_oe(lane_oe)
  );

  always #2 clk = ~clk;

  int mp [4][7] = '{'{1, 0, 7, 6, 4, 3, 2},
                    '{9, 8, 18, 15, 14, 13, 12},
                    '{20, 19, 26, 25, 24, 22, 21},
                    '{5, 27, 23, 17, 16, 11, 10}};
  string lane_tag [4] = '{"R3", "R4", "R5", "R6"};

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  bit         started = 0;
  bit         m_rst, m_oe, m_valid, m_pq;
  int         m_cnt, m_pos;
  logic [27:0] m_cap, m_frame, acc;
  int         cyc = 0;
  int         last_rise = -1;
  bit         prev_clk = 0;

  always @(posedge clk) begin
    bit hit;
    bit was_valid;
    cyc++;
    started = 1;
    if (rst) begin
      m_rst = 1; m_oe = 0; m_valid = 0; m_pq = 0; m_cnt = 0; m_pos = 0;
      m_cap = '0; m_frame = '0;
    end else begin
      m_rst = 0;
      hit = edge_rise ? (pix_clk && !m_pq) : (!pix_clk && m_pq);
      m_oe = run;
      was_valid = m_valid;
      if (!run) m_cnt = 0;
      else if (m_cnt < LOCK) m_cnt++;
      m_valid = run && (m_cnt == LOCK);
      if (m_valid) begin
        m_pos = was_valid ? (m_pos + 1) % 7 : 0;
        if (m_pos == 0) m_frame = m_cap;
      end
      if (hit) m_cap = pix_word;
      m_pq = pix_clk;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      if (!m_oe) begin
        chk(lane_oe == 1'b0 && lane_dat == 4'd0 && lane_clk == 1'b0,
            m_rst ? "R10" : "R8", {26'd0, lane_oe, lane_clk, lane_dat}, 32'd0);
        last_rise = -1;
      end else if (!m_valid) begin
        chk(lane_oe == 1'b1 && lane_dat == 4'd0 && lane_clk == 1'b0, "R9",
            {26'd0, lane_oe, lane_clk, lane_dat}, 32'h20);
        last_rise = -1;
      end else begin
        chk(lane_oe == 1'b1, "R9", {31'd0, lane_oe}, 32'd1);
        for (int l = 0; l < 4; l++) begin
          chk(lane_dat[l] == m_frame[mp[l][m_pos]], lane_tag[l],
              {31'd0, lane_dat[l]}, {31'd0, m_frame[mp[l][m_pos]]});
          acc[mp[l][m_pos]] = lane_dat[l];
        end
        chk(lane_clk == (m_pos < 4), "R7", {31'd0, lane_clk}, {31'd0, m_pos < 4});
        if (lane_clk && !prev_clk) begin
          if (last_rise >= 0)
            chk(cyc - last_rise == 7, "R11", cyc - last_rise, 32'd7);
          last_rise = cyc;
        end
        if (m_pos == 6)
          chk(acc == m_frame, "R1,R2", {4'd0, acc}, {4'd0, m_frame});
      end
      prev_clk = lane_clk;
    end
  end

  int pcnt = 0;
  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      pcnt = (pcnt + 1) % 7;
      pix_clk = (pcnt < 4);
      if (pcnt == 2) pix_word = 28'($urandom);
    end
  endtask

  task automatic wrap;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      wrap();
    end
  end

  initial begin
    step(6);                       // R10 reset window
    rst = 1'b0;
    step(4);                       // R8 idle shut down
    edge_rise = 1'b1;
    run = 1'b1;
    step(LOCK + 300);              // R9 lock, then R1..R7 rising capture
    pcnt = (pcnt + 3) % 7;         // shift pixel phase against the frame
    step(200);
    pcnt = (pcnt + 2) % 7;
    step(200);
    run = 1'b0;
    step(12);                      // R8 shutdown
    edge_rise = 1'b0;
    run = 1'b1;
    step(LOCK / 2);                // partial lock
    run = 1'b0;
    step(3);
    run = 1'b1;
    step(LOCK + 300);              // R9 restart, falling capture
    for (int k = 0; k < 7; k++) begin
      pcnt = (pcnt + 1) % 7;       // walk the capture edge over every slot
      step(120);
    end
    rst = 1'b1;
    step(4);                       // R10 reset while running
    wrap();
  end
endmodule